// File: doc/BRIEF.md
# Buffered I2C Slave Receiver

This block is the receive side of an I2C target that collects a whole programmed block of data bytes before it asks software for service. It watches SCL and SDA through a synchronizer clocked by the system clock and detects START and STOP conditions. It matches the incoming address byte against its own 7-bit address and, when enabled, the General Call address. It acknowledges data bytes on SDA through an open-drain enable and stores them in a small receive buffer. When the block is complete, or the master ends the transfer early, it sets an interrupt and reports an 8-bit status code. It holds SCL low until software clears the interrupt.

Software sets the block length and an optional last-byte flag through a count write. It acknowledges, continues or releases the bus through a control write. That write also carries the address-enable bit and a START request bit. A START request made while releasing is kept pending and is shown on `start_req` once the bus is free. Received bytes are read in arrival order through a read strobe.

Top module: `bsr_top`

## Requirements
- R1: During and after reset `irq_n` is 1, `status` is F8h, `start_req` is 0, and neither `sda_oe` nor `scl_oe` is driven.
- R2: After a START, the block acknowledges a write address byte that carries its own address, provided the address-enable bit is set. It then acknowledges every byte of the programmed count. After the last of those bytes it drives `irq_n` low with status 80h.
- R3: With the last-byte flag set, every byte of the block is acknowledged except the last one, which gets a NACK. The status is then 88h for a transfer to its own address and E8h for a General Call transfer.
- R4: With `gc_en`=1, a write to address 0 is acknowledged, and a fully acknowledged block reports E0h. With `gc_en`=0, address 0 gets no acknowledge and raises no interrupt.
- R5: A STOP or repeated START that arrives while the block is addressed and a block is still incomplete reports status A0h. Every byte received before it was acknowledged and is kept in the buffer.
- R6: `scl_oe` is 1 exactly while the interrupt is pending. The block never drives SDA while the interrupt is pending.
- R7: A control write clears the interrupt on the next cycle. After status 80h or E0h, it lets reception continue with a fresh block of the programmed count.
- R8: After status 88h, E8h or A0h, a control write returns the block to not-addressed mode. The address-enable bit written then decides whether its own address is acknowledged later.
- R9: A control write with the START bit set in state 88h, E8h or A0h raises `start_req` only once a STOP has left the bus free. A control write with that bit clear drops `start_req`.
- R10: A programmed byte count of 0 behaves as a count of 1.
- R11: An address byte with a different address, or with the read bit (bit 0 = 1), is not acknowledged and raises no interrupt.
- R12: Bytes are read in arrival order. `rd_data` is valid on the cycle after the `rd_en` pulse, from a buffer holding FIFO_DEPTH (default 16) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own target address |
| gc_en | input | 1 | Enable General Call recognition |
| ctl_wr | input | 1 | Control write strobe; clears the interrupt |
| ctl_sta | input | 1 | Control: request a START when the bus is free |
| ctl_aa | input | 1 | Control: address-enable bit |
| cnt_wr | input | 1 | Count write strobe |
| cnt_lb | input | 1 | Count: NACK the last byte |
| cnt_bc | input | 7 | Count: bytes per block (0 means 1) |
| rd_en | input | 1 | Read strobe; pops one buffered byte |
| rd_data | output | 8 | Buffered byte, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt |
| status | output | 8 | Status code |
| start_req | output | 1 | Pending START request with the bus free |

## Verification
The assertions take several things for granted. Software never reads more bytes than it has received, and never writes more than FIFO_DEPTH bytes into the buffer before draining it. The bus master keeps SCL stable across several system clocks and changes SDA only while SCL is low, except to form a START or STOP. The stimulus keeps within these limits. Its master model holds each SCL phase for ten clocks and waits three clocks after a falling SCL before moving SDA. It waits while the block stretches the clock. After every interrupt it drains exactly the bytes it pushed.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam logic [7:0] ST_OWN_ACK  = 8'h80;
  localparam logic [7:0] ST_OWN_NACK = 8'h88;
  localparam logic [7:0] ST_GC_ACK   = 8'hE0;
  localparam logic [7:0] ST_GC_NACK  = 8'hE8;
  localparam logic [7:0] ST_ENDED    = 8'hA0;
  localparam logic [7:0] ST_NONE     = 8'hF8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_HOLD
  } bsr_state_t;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/bsr_fifo.sv
module bsr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;
  logic          do_push, do_pop;

  assign do_push = push && (level != AW'(0) + (AW+1)'(DEPTH));
  assign do_pop  = pop && (level != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
    if (do_pop)  pop_data  <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R12
  fifo_level_chk: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  // R12
  fifo_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !do_push) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          ctl_wr,
  input  logic          ctl_sta,
  input  logic          ctl_aa,
  input  logic          cnt_wr,
  input  logic          cnt_lb,
  input  logic [CW-1:0] cnt_bc,
  output logic          sda_oe,
  output logic          si,
  output logic [7:0]    status,
  output logic          start_req,
  output logic          push,
  output logic [DW-1:0] push_data
);
  localparam int BCW = $clog2(DW + 1);

  bsr_state_t    state;
  logic [DW-1:0] sh;
  logic [BCW-1:0] bitc;
  logic [CW-1:0] rcv, bc_r;
  logic          lb_r, aa_r, is_gc, nack_r, last_r, sta_pend, bus_free;
  logic [CW:0]   bc_eff;
  logic          last_now, own_hit, gc_hit, end_state;

  assign bc_eff    = (bc_r == '0) ? (CW+1)'(1) : {1'b0, bc_r};
  assign last_now  = ({1'b0, rcv} + (CW+1)'(1)) >= bc_eff;
  assign own_hit   = aa_r && (sh[DW-1:1] == own_addr) && !sh[0];
  assign gc_hit    = gc_en && (sh[DW-1:1] == '0) && !sh[0];
  assign end_state = (status == ST_OWN_NACK) || (status == ST_GC_NACK) ||
                     (status == ST_ENDED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sh        <= '0;
      bitc      <= '0;
      rcv       <= '0;
      bc_r      <= '0;
      lb_r      <= 1'b0;
      aa_r      <= 1'b0;
      is_gc     <= 1'b0;
      nack_r    <= 1'b0;
      last_r    <= 1'b0;
      sta_pend  <= 1'b0;
      bus_free  <= 1'b1;
      start_req <= 1'b0;
      sda_oe    <= 1'b0;
      si        <= 1'b0;
      status    <= ST_NONE;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push      <= 1'b0;
      start_req <= sta_pend && bus_free;
      if (start_ev) begin
        bus_free <= 1'b0;
        sta_pend <= 1'b0;
      end else if (stop_ev) begin
        bus_free <= 1'b1;
      end
      if (cnt_wr) begin
        bc_r <= cnt_bc;
        lb_r <= cnt_lb;
      end
      if (ctl_wr) begin
        aa_r <= ctl_aa;
        si   <= 1'b0;
        if (!ctl_sta)               sta_pend <= 1'b0;
        else if (si && end_state)   sta_pend <= 1'b1;
      end

      unique case (state)
        S_IDLE: begin
          if (start_ev) begin
            state <= S_ADDR;
            bitc  <= '0;
          end
        end
        S_ADDR: begin
          if (stop_ev) begin
            state <= S_IDLE;
          end else if (start_ev) begin
            bitc <= '0;
          end else if (scl_rise && bitc < BCW'(DW)) begin
            sh   <= {sh[DW-2:0], sda_s};
            bitc <= bitc + 1'b1;
          end else if (scl_fall && bitc == BCW'(DW)) begin
            if (own_hit || gc_hit) begin
              sda_oe <= 1'b1;
              is_gc  <= gc_hit;
              state  <= S_AACK;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_DATA;
            bitc   <= '0;
            rcv    <= '0;
          end
        end
        S_DATA, S_DACK: begin
          if (start_ev || stop_ev) begin
            sda_oe <= 1'b0;
            si     <= 1'b1;
            status <= ST_ENDED;
            state  <= S_HOLD;
          end else if (state == S_DATA) begin
            if (scl_rise && bitc < BCW'(DW)) begin
              sh   <= {sh[DW-2:0], sda_s};
              bitc <= bitc + 1'b1;
              if (bitc == BCW'(DW-1)) begin
                push      <= 1'b1;
                push_data <= {sh[DW-2:0], sda_s};
              end
            end else if (scl_fall && bitc == BCW'(DW)) begin
              last_r <= last_now;
              nack_r <= last_now && lb_r;
              sda_oe <= !(last_now && lb_r);
              state  <= S_DACK;
            end
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            rcv    <= rcv + 1'b1;
            if (last_r) begin
              si     <= 1'b1;
              status <= is_gc ? (nack_r ? ST_GC_NACK : ST_GC_ACK)
                              : (nack_r ? ST_OWN_NACK : ST_OWN_ACK);
              state  <= S_HOLD;
            end else begin
              state <= S_DATA;
              bitc  <= '0;
            end
          end
        end
        S_HOLD: begin
          if (ctl_wr) begin
            if (status == ST_OWN_ACK || status == ST_GC_ACK) begin
              state <= S_DATA;
              bitc  <= '0;
              rcv   <= '0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(si) |-> (status == ST_OWN_ACK || status == ST_OWN_NACK ||
                   status == ST_GC_ACK  || status == ST_GC_NACK  ||
                   status == ST_ENDED));

  // R6
  no_sda_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    si |-> !sda_oe);

  // R7
  si_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && si) |=> !si);

  // R9
  start_req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(start_req) |-> (!si && bus_free));
endmodule

// File: rtl/bsr_top.sv
module bsr_top #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 7,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ctl_wr,
  input  logic              ctl_sta,
  input  logic              ctl_aa,
  input  logic              cnt_wr,
  input  logic              cnt_lb,
  input  logic [CNT_W-1:0]  cnt_bc,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n,
  output logic [7:0]        status,
  output logic              start_req
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic si, push;
  logic [DATA_W-1:0] push_data;

  bsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bsr_ctrl #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .gc_en(gc_en), .ctl_wr(ctl_wr), .ctl_sta(ctl_sta),
    .ctl_aa(ctl_aa), .cnt_wr(cnt_wr), .cnt_lb(cnt_lb), .cnt_bc(cnt_bc),
    .sda_oe(sda_oe), .si(si), .status(status), .start_req(start_req),
    .push(push), .push_data(push_data)
  );

  bsr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(rd_en), .pop_data(rd_data)
  );

  assign scl_oe = si;
  assign irq_n  = ~si;

  logic scl_s_unused;
  assign scl_s_unused = scl_s;
endmodule

// File: tb/tb_bsr_top.sv
`timescale 1ns/1ps
module tb_bsr_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_ln, sda_ln;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 1'b0;
  logic ctl_wr = 1'b0, ctl_sta = 1'b0, ctl_aa = 1'b0;
  logic cnt_wr = 1'b0, cnt_lb = 1'b0;
  logic [6:0] cnt_bc = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data, status;
  logic irq_n, start_req;

  int checks = 0, errors = 0;
  logic [7:0] exp_status[$];
  logic [7:0] exp_data[$];
  logic irq_prev = 1'b1;

  always #10 clk = ~clk;

  assign scl_ln = scl_m & ~scl_oe;
  assign sda_ln = sda_m & ~sda_oe;

  bsr_top dut (
    .clk(clk), .rst(rst), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .ctl_wr(ctl_wr), .ctl_sta(ctl_sta), .ctl_aa(ctl_aa),
    .cnt_wr(cnt_wr), .cnt_lb(cnt_lb), .cnt_bc(cnt_bc),
    .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n),
    .status(status), .start_req(start_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops an expected status on each new interrupt.
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_prev && !irq_n) begin
        if (exp_status.size() == 0)
          chk(1'b0, "R11 unexpected irq", status, 0);
        else begin
          logic [7:0] e;
          e = exp_status.pop_front();
          chk(status == e, "R2/R3/R4/R5 status", status, e);
        end
      end
      irq_prev = irq_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_ln) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; clks(H); scl_high(); clks(H);
    sda_m = 1'b0; clks(H); scl_m = 1'b0; clks(3);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; clks(H); scl_high(); clks(H);
    sda_m = 1'b1; clks(H);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; clks(H); scl_high(); clks(H); scl_m = 1'b0; clks(3);
    end
    sda_m = 1'b1; clks(H); scl_high(); clks(H/2);
    ack = ~sda_ln; clks(H/2); scl_m = 1'b0; clks(3);
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    m_byte(b, a);
    chk(a == exp_ack, req, a, exp_ack);
  endtask

  task automatic cfg(input logic [6:0] bc, input bit lb);
    cnt_bc = bc; cnt_lb = lb; cnt_wr = 1'b1; clks(1); cnt_wr = 1'b0;
  endtask

  task automatic ctl(input bit aa, input bit sta);
    ctl_aa = aa; ctl_sta = sta; ctl_wr = 1'b1; clks(1); ctl_wr = 1'b0;
    clks(2);
    chk(scl_oe == 1'b0 && irq_n == 1'b1, "R6/R7 released after clear", scl_oe, 0);
  endtask

  task automatic wait_irq();
    int n = 0;
    while (irq_n && n < 3000) begin clks(1); n++; end
    chk(!irq_n, "R2 irq raised", irq_n, 0);
    chk(scl_oe == 1'b1, "R6 scl held while pending", scl_oe, 1);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_data.pop_front();
      rd_en = 1'b1; clks(1); rd_en = 1'b0;
      chk(rd_data == e, "R12 buffered byte", rd_data, e);
    end
  endtask

  task automatic data(input logic [7:0] b, input bit exp_ack, input string req);
    exp_data.push_back(b);
    send(b, exp_ack, req);
  endtask

  initial begin
    clks(4);
    // R1: reset state
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(!sda_oe && !scl_oe, "R1 no drive", {sda_oe, scl_oe}, 0);
    chk(start_req == 1'b0, "R1 start_req", start_req, 0);
    rst = 1'b0; clks(2);

    // R2: own address, three acknowledged bytes
    cfg(7'd3, 1'b0); ctl(1'b1, 1'b0);
    exp_status.push_back(8'h80);
    m_start();
    send(8'h54, 1'b1, "R2 own address ack");
    data(8'h11, 1'b1, "R2 data ack");
    data(8'h22, 1'b1, "R2 data ack");
    data(8'h33, 1'b1, "R2 data ack");
    wait_irq(); drain(3);

    // R7: continue with a fresh block
    exp_status.push_back(8'h80);
    ctl(1'b1, 1'b0);
    data(8'h44, 1'b1, "R7 data ack");
    data(8'h55, 1'b1, "R7 data ack");
    data(8'h66, 1'b1, "R7 data ack");
    wait_irq(); drain(3);

    // R3: last byte NACK, status 88h; R9 START request
    cfg(7'd2, 1'b1);
    exp_status.push_back(8'h88);
    ctl(1'b1, 1'b0);
    data(8'h77, 1'b1, "R3 non-last ack");
    data(8'h88, 1'b0, "R3 last byte nack");
    wait_irq(); drain(2);
    ctl(1'b1, 1'b1);
    clks(4);
    chk(start_req == 1'b0, "R9 held while bus busy", start_req, 0);
    m_stop();
    chk(start_req == 1'b1, "R9 asserted when bus free", start_req, 1);
    ctl(1'b1, 1'b0);
    chk(start_req == 1'b0, "R9 dropped by clear", start_req, 0);

    // R4: General Call, E0h then E8h
    gc_en = 1'b1;
    cfg(7'd2, 1'b0);
    exp_status.push_back(8'hE0);
    m_start();
    send(8'h00, 1'b1, "R4 general call ack");
    data(8'hA1, 1'b1, "R4 data ack");
    data(8'hB2, 1'b1, "R4 data ack");
    wait_irq(); drain(2);
    cfg(7'd1, 1'b1);
    exp_status.push_back(8'hE8);
    ctl(1'b1, 1'b0);
    data(8'hC3, 1'b0, "R3 general call last nack");
    wait_irq(); drain(1);
    ctl(1'b1, 1'b0);
    m_stop();

    // R5: STOP before the block completes
    cfg(7'd4, 1'b1);
    exp_status.push_back(8'hA0);
    m_start();
    send(8'h54, 1'b1, "R5 address ack");
    data(8'hD4, 1'b1, "R5 early byte ack");
    data(8'hE5, 1'b1, "R5 no nack before stop");
    m_stop();
    wait_irq(); drain(2);
    ctl(1'b0, 1'b0);

    // R8: address-enable cleared, own address ignored
    m_start();
    send(8'h54, 1'b0, "R8 own address ignored with aa=0");
    m_stop();
    chk(irq_n == 1'b1, "R8 no irq", irq_n, 1);

    // R4: General Call disabled
    gc_en = 1'b0;
    m_start();
    send(8'h00, 1'b0, "R4 general call ignored");
    m_stop();

    // R11: other address and read bit
    ctl(1'b1, 1'b0);
    m_start();
    send(8'h26, 1'b0, "R11 other address nack");
    m_stop();
    m_start();
    send(8'h55, 1'b0, "R11 read bit nack");
    m_stop();
    chk(irq_n == 1'b1, "R11 no irq", irq_n, 1);

    // R10: count 0 acts as 1; R8 address recognized again
    cfg(7'd0, 1'b0);
    exp_status.push_back(8'h80);
    m_start();
    send(8'h54, 1'b1, "R8 own address recognized again");
    data(8'hF6, 1'b1, "R10 single byte ack");
    wait_irq(); drain(1);
    exp_status.push_back(8'hA0);
    ctl(1'b1, 1'b0);
    m_stop();
    wait_irq();
    ctl(1'b1, 1'b0);

    clks(10);
    chk(exp_status.size() == 0, "R2 all statuses seen", exp_status.size(), 0);
    finish_sim();
  end
endmodule